// File: doc/BRIEF.md
# Boot Image Loader with CRC Fallback

This block decides, right after reset, which program the processor will run. Program RAM already holds a complete default image, so the system can run with no external image at all. The loader reads a candidate image from an external serial EEPROM one byte at a time, using a request/valid byte handshake. It computes a CRC-32 over the payload and compares the result with the check value stored in the image header. The EEPROM image is copied over the default RAM contents only when the two match. In every other case the default image stays in place: a mismatch, a bad length, an EEPROM that stops answering, or a held override button.

The image is read twice. The first pass computes the CRC and writes nothing. The second pass streams the payload into program RAM. A parameterised settle interval follows either pass, so that analogue circuits have time to stabilise. After that interval the processor reset is released and a status bit reports which image is running.

Top module: `boot_image_loader`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cpu_rst_n`, `boot_done`, `src_eeprom`, `ee_req` and `pram_we` are all 0.
- R2: The EEPROM image begins with an 8-byte header. Bytes 0..3 hold the payload length and bytes 4..7 hold the expected CRC, both little-endian. The payload starts at EEPROM address 8. Bytes are requested in strictly ascending address order: first the header, then a checking pass over the payload, then a copy pass over the payload.
- R3: The check value is a reflected CRC-32 over the payload bytes only. It uses polynomial 0xEDB88320, starts from 0xFFFFFFFF, processes one byte per step and inverts the result at the end. The comparison is completed before any program RAM write takes place.
- R4: When the CRC matches, payload byte i is written to program RAM address i. The writes go in ascending order, exactly one per payload byte, and `src_eeprom` is 1 when the processor is released.
- R5: When the CRC does not match, no program RAM write occurs and `src_eeprom` is 0 after release.
- R6: A header length of 0, or one larger than the program RAM depth (2^PRAM_AW bytes), causes fallback. No payload byte (address 8 or above) is requested, no RAM write occurs, and `src_eeprom` is 0.
- R7: If `btn[SKIP_BTN]` (bit 7 by default) is 1 in the first cycle after reset, no EEPROM request and no RAM write are made, and `src_eeprom` is 0. Holding any other button has no effect on loading.
- R8: If a request goes unanswered for TIMEOUT_CYC cycles, the loader abandons the EEPROM and falls back with `src_eeprom` 0. If this happens before the copy pass, no RAM write occurs.
- R9: Between the last EEPROM request or RAM write and the release of the processor there are at least SETTLE_CYC and at most SETTLE_CYC+4 cycles. After release, no request and no write occur.
- R10: While `ee_req` is high and `ee_valid` is low, `ee_addr` holds its value.
- R11: `cpu_rst_n` equals `boot_done`. Once it is 1 it stays 1 until reset. `src_eeprom` is never 1 while `boot_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn | input | BTN_N | User buttons; bit SKIP_BTN forces the default image |
| ee_req | output | 1 | Byte read request to the EEPROM |
| ee_addr | output | ADDR_W | Byte address of the request |
| ee_rdata | input | 8 | Returned byte |
| ee_valid | input | 1 | `ee_rdata` is valid for the current request |
| pram_we | output | 1 | Program RAM write strobe |
| pram_addr | output | PRAM_AW | Program RAM byte address |
| pram_wdata | output | 8 | Program RAM write data |
| cpu_rst_n | output | 1 | Processor reset, released at the end of boot |
| boot_done | output | 1 | Boot sequence complete |
| src_eeprom | output | 1 | Running image came from the EEPROM |

## Verification
The checker module watches every cycle for the following properties:
- the request address stays stable while a request is pending;
- boot completion is sticky and equal to the processor reset;
- no request or write occurs after release, and the release edge is preceded by a quiet cycle;
- RAM write addresses advance by one;
- the source bit never appears before completion.

Other behaviours depend on whole scenarios, and only the bench can show them:
- whether a given image was accepted, and that its bytes arrived at the right RAM addresses;
- that a corrupted CRC, an out-of-range length, a silent EEPROM or the held button leaves RAM untouched;
- that the settle interval has the right length.

// File: rtl/boot_pkg.sv
package boot_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HDR    = 3'd1,
        ST_HCHK   = 3'd2,
        ST_SUM    = 3'd3,
        ST_CMP    = 3'd4,
        ST_COPY   = 3'd5,
        ST_SETTLE = 3'd6,
        ST_RUN    = 3'd7
    } boot_st_e;

    localparam int HDR_BYTES = 8;
endpackage

// File: rtl/crc32_step.sv
module crc32_step #(
    parameter logic [31:0] POLY = 32'hEDB88320
) (
    input  logic [31:0] crc_in,
    input  logic [7:0]  data,
    output logic [31:0] crc_out
);
    logic [31:0] acc;

    always_comb begin
        acc = crc_in ^ {24'd0, data};
        for (int b = 0; b < 8; b++) begin
            if (acc[0]) acc = (acc >> 1) ^ POLY;
            else        acc = acc >> 1;
        end
        crc_out = acc;
    end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                    cnt_d = '0;
        else if (en && cnt_q != LIM) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == LIM);
endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader
    import boot_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PRAM_AW     = 6,
    parameter int BTN_N       = 8,
    parameter int SKIP_BTN    = 7,
    parameter int SETTLE_CYC  = 32,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BTN_N-1:0]   btn,
    output logic               ee_req,
    output logic [ADDR_W-1:0]  ee_addr,
    input  logic [7:0]         ee_rdata,
    input  logic               ee_valid,
    output logic               pram_we,
    output logic [PRAM_AW-1:0] pram_addr,
    output logic [7:0]         pram_wdata,
    output logic               cpu_rst_n,
    output logic               boot_done,
    output logic               src_eeprom
);
    localparam int DEPTH = 1 << PRAM_AW;
    localparam int CNT_W = PRAM_AW + 1;
    localparam logic [ADDR_W-1:0] PAY_BASE = ADDR_W'(HDR_BYTES);
    localparam logic [ADDR_W-1:0] HDR_LAST = ADDR_W'(HDR_BYTES - 1);

    typedef struct packed {
        boot_st_e           st;
        logic [ADDR_W-1:0]  addr;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   len;
        logic [63:0]        hdr;
        logic [31:0]        crc;
        logic               src;
        logic               we;
        logic [PRAM_AW-1:0] waddr;
        logic [7:0]         wdata;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [31:0] crc_nx;
    logic [31:0] len32;
    logic        req_w;
    logic        tmo_hit;
    logic        settle_hit;
    logic        last_byte;

    crc32_step #(.POLY(32'hEDB88320)) u_crc (
        .crc_in  (r_q.crc),
        .data    (ee_rdata),
        .crc_out (crc_nx)
    );

    wait_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!req_w || ee_valid),
        .en    (req_w),
        .hit   (tmo_hit)
    );

    wait_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (r_q.st != ST_SETTLE),
        .en    (r_q.st == ST_SETTLE),
        .hit   (settle_hit)
    );

    assign req_w     = (r_q.st == ST_HDR) || (r_q.st == ST_SUM) || (r_q.st == ST_COPY);
    assign len32     = r_q.hdr[31:0];
    assign last_byte = (r_q.cnt == r_q.len - CNT_W'(1));

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (btn[SKIP_BTN]) r_d.st = ST_SETTLE;
                else begin
                    r_d.st   = ST_HDR;
                    r_d.addr = '0;
                end
            end
            ST_HDR: begin
                if (ee_valid) begin
                    r_d.hdr  = {ee_rdata, r_q.hdr[63:8]};
                    r_d.addr = r_q.addr + ADDR_W'(1);
                    if (r_q.addr == HDR_LAST) r_d.st = ST_HCHK;
                end else if (tmo_hit) begin
                    r_d.st = ST_SETTLE;
                end
            end
            ST_HCHK: begin
                if (len32 == 32'd0 || len32 > 32'(DEPTH)) r_d.st = ST_SETTLE;
                else begin
                    r_d.len = len32[CNT_W-1:0];
                    r_d.crc = '1;
                    r_d.cnt = '0;
                    r_d.st  = ST_SUM;
                end
            end
            ST_SUM: begin
                if (ee_valid) begin
                    r_d.crc  = crc_nx;
                    r_d.addr = r_q.addr + ADDR_W'(1);
                    r_d.cnt  = r_q.cnt + CNT_W'(1);
                    if (last_byte) r_d.st = ST_CMP;
                end else if (tmo_hit) begin
                    r_d.st = ST_SETTLE;
                end
            end
            ST_CMP: begin
                if (~r_q.crc == r_q.hdr[63:32]) begin
                    r_d.st   = ST_COPY;
                    r_d.addr = PAY_BASE;
                    r_d.cnt  = '0;
                end else begin
                    r_d.st = ST_SETTLE;
                end
            end
            ST_COPY: begin
                if (ee_valid) begin
                    r_d.we    = 1'b1;
                    r_d.waddr = r_q.cnt[PRAM_AW-1:0];
                    r_d.wdata = ee_rdata;
                    r_d.addr  = r_q.addr + ADDR_W'(1);
                    r_d.cnt   = r_q.cnt + CNT_W'(1);
                    if (last_byte) begin
                        r_d.st  = ST_SETTLE;
                        r_d.src = 1'b1;
                    end
                end else if (tmo_hit) begin
                    r_d.st = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (settle_hit) r_d.st = ST_RUN;
            end
            ST_RUN: ;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ee_req     = req_w;
    assign ee_addr    = r_q.addr;
    assign pram_we    = r_q.we;
    assign pram_addr  = r_q.waddr;
    assign pram_wdata = r_q.wdata;
    assign boot_done  = (r_q.st == ST_RUN);
    assign cpu_rst_n  = boot_done;
    assign src_eeprom = boot_done && r_q.src;
endmodule

// File: rtl/boot_image_loader_chk.sv
module boot_image_loader_chk #(
    parameter int ADDR_W  = 16,
    parameter int PRAM_AW = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ee_req,
    input logic [ADDR_W-1:0]  ee_addr,
    input logic               ee_valid,
    input logic               pram_we,
    input logic [PRAM_AW-1:0] pram_addr,
    input logic               cpu_rst_n,
    input logic               boot_done,
    input logic               src_eeprom
);
    // R10: a pending request keeps its address
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_valid) |=> (!ee_req || $stable(ee_addr)));

    // R11: completion is sticky
    p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);

    // R11: processor reset follows completion
    p_cpu_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n == boot_done);

    // R11: source flag only after completion
    p_src_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        src_eeprom |-> boot_done);

    // R9: no EEPROM or RAM traffic after release
    p_quiet_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> (!ee_req && !pram_we));

    // R9: release is preceded by a quiet cycle
    p_settle_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_done) |-> $past(!ee_req && !pram_we));

    // R4: RAM writes advance one address at a time
    p_wr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pram_we |=> (!pram_we || pram_addr == $past(pram_addr) + PRAM_AW'(1)));
endmodule

bind boot_image_loader boot_image_loader_chk #(.ADDR_W(ADDR_W), .PRAM_AW(PRAM_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ee_req     (ee_req),
    .ee_addr    (ee_addr),
    .ee_valid   (ee_valid),
    .pram_we    (pram_we),
    .pram_addr  (pram_addr),
    .cpu_rst_n  (cpu_rst_n),
    .boot_done  (boot_done),
    .src_eeprom (src_eeprom)
);

// File: tb/boot_image_loader_bench.sv
`timescale 1ns/1ps
module boot_image_loader_bench;
    localparam int ADDR_W = 16, PRAM_AW = 6, BTN_N = 8, SKIP = 7;
    localparam int SETTLE = 32, TMO = 64, DEPTH = 64, LAT = 2;

    logic clk = 0, rst_n = 0;
    logic [BTN_N-1:0] btn = '0;
    logic ee_req, ee_valid = 0, pram_we, cpu_rst_n, boot_done, src_eeprom;
    logic [ADDR_W-1:0] ee_addr;
    logic [7:0] ee_rdata = '0, pram_wdata;
    logic [PRAM_AW-1:0] pram_addr;

    boot_image_loader #(.ADDR_W(ADDR_W), .PRAM_AW(PRAM_AW), .BTN_N(BTN_N), .SKIP_BTN(SKIP),
        .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) u_boot_image_loader (
        .clk(clk), .rst_n(rst_n), .btn(btn), .ee_req(ee_req), .ee_addr(ee_addr),
        .ee_rdata(ee_rdata), .ee_valid(ee_valid), .pram_we(pram_we), .pram_addr(pram_addr),
        .pram_wdata(pram_wdata), .cpu_rst_n(cpu_rst_n), .boot_done(boot_done),
        .src_eeprom(src_eeprom));

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    logic [7:0] mem [0:255];
    logic [7:0] exp_q [$];
    int  silent = 0, lat_cnt = 0, served = 0, img_len = 0;
    int  mon_en = 0, cyc = 0, last_act = 0, widx = 0, gap = -1, req_cycles = 0, max_addr = 0;
    logic done_prev = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ref(input int len);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'd0, mem[8+i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    // R2: header bytes 0..3 length LE, 4..7 CRC LE, payload from 8
    task automatic build(input int len, input int seed, input bit corrupt);
        logic [31:0] c;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * seed + 11);
        for (int i = 0; i < 4; i++) mem[i] = 8'(len >> (8 * i));
        c = crc_ref((len > 0 && len <= 200) ? len : 0);
        if (corrupt) c = c ^ 32'h0000_0100;
        for (int i = 0; i < 4; i++) mem[4+i] = 8'(c >> (8 * i));
        img_len = len;
    endtask

    // EEPROM model: answers LAT cycles after a request, addresses checked for order
    always @(negedge clk) begin
        if (!rst_n) begin
            ee_valid = 0; lat_cnt = 0; served = 0;
        end else if (ee_req && silent == 0 && !ee_valid) begin
            if (lat_cnt == LAT) begin
                int exp_a;
                exp_a = (served < 8) ? served : 8 + ((served - 8) % img_len);
                check(ee_addr == ADDR_W'(exp_a), "R2", "request address", ee_addr, exp_a);
                ee_rdata = mem[ee_addr[7:0]];
                ee_valid = 1; lat_cnt = 0; served++;
            end else lat_cnt++;
        end else ee_valid = 0;
    end

    // Per-cycle reference comparison
    always @(negedge clk) begin
        if (mon_en != 0) begin
            cyc++;
            if (ee_req) begin
                req_cycles++;
                if (int'(ee_addr) > max_addr) max_addr = int'(ee_addr);
            end
            if (ee_req || pram_we) last_act = cyc;
            check(cpu_rst_n == boot_done, "R11", "cpu_rst_n vs boot_done", cpu_rst_n, boot_done);
            check(!(boot_done && (ee_req || pram_we)), "R9", "traffic after release", 1, 0);
            check(!(done_prev && !boot_done), "R11", "boot_done dropped", 0, 1);
            if (pram_we) begin
                if (exp_q.size() == 0) check(0, "R5", "unexpected RAM write", pram_addr, -1);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(pram_addr == PRAM_AW'(widx), "R4", "write address", pram_addr, widx);
                    check(pram_wdata == e, "R4", "write data", pram_wdata, e);
                    widx++;
                end
            end
            if (boot_done && !done_prev) gap = cyc - last_act;
            done_prev = boot_done;
        end
    end

    task automatic run(input string name, input logic [BTN_N-1:0] b, input int sil,
                       input bit expect_copy, input string freq);
        @(negedge clk);
        rst_n = 0; btn = b; silent = sil;
        exp_q.delete();
        if (expect_copy) for (int i = 0; i < img_len; i++) exp_q.push_back(mem[8+i]);
        repeat (3) begin
            @(negedge clk);
            check(!cpu_rst_n && !boot_done && !ee_req && !pram_we && !src_eeprom,
                  "R1", {name, " outputs in reset"}, 1, 0);
        end
        rst_n = 1;
        mon_en = 1; cyc = 0; last_act = 0; widx = 0; gap = -1; req_cycles = 0; max_addr = 0;
        done_prev = 0;
        @(negedge clk); #0.1;
        check(!cpu_rst_n && !boot_done && !pram_we, "R1", {name, " first cycle"}, boot_done, 0);
        for (int i = 0; i < 2000 && !boot_done; i++) @(negedge clk);
        @(negedge clk);
        check(boot_done == 1, "R9", {name, " release reached"}, boot_done, 1);
        check(src_eeprom == expect_copy, freq, {name, " src_eeprom"}, src_eeprom, expect_copy);
        check(exp_q.size() == 0, "R4", {name, " writes missing"}, exp_q.size(), 0);
        check(gap >= SETTLE && gap <= SETTLE + 4, "R9", {name, " settle gap"}, gap, SETTLE);
        mon_en = 0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R3 R4: good image, mid-size
        build(20, 37, 0);
        run("good20", '0, 0, 1, "R4");
        // R4: image exactly filling RAM
        build(DEPTH, 91, 0);
        run("good_full", '0, 0, 1, "R3");
        // R5: stored CRC wrong, no write
        build(20, 37, 1);
        run("badcrc", '0, 0, 0, "R5");
        check(max_addr == 8 + 19, "R5", "checking pass only", max_addr, 27);
        // R7: skip button held
        build(20, 37, 0);
        run("skip", 8'h80, 0, 0, "R7");
        check(req_cycles == 0, "R7", "requests with skip held", req_cycles, 0);
        // R7: another button has no effect
        run("other_btn", 8'h08, 0, 1, "R7");
        // R6: zero and oversized length
        build(0, 5, 0);
        run("len0", '0, 0, 0, "R6");
        check(max_addr < 8, "R6", "payload read with len 0", max_addr, 7);
        build(DEPTH + 1, 5, 0);
        run("len_big", '0, 0, 0, "R6");
        check(max_addr < 8, "R6", "payload read with big len", max_addr, 7);
        // R8: EEPROM silent
        build(20, 37, 0);
        run("silent", '0, 1, 0, "R8");
        check(req_cycles >= TMO && req_cycles <= TMO + 3, "R8", "timeout length", req_cycles, TMO);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule